// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache Controller

This block sits between a processor-side word port and a memory port that moves whole lines. It holds 64 sets of four 64-byte lines each. A request is looked up by comparing all four stored tags of its set at the same time. A hit is served from the on-chip arrays in a single cycle. Stores that hit change only the cached copy and mark the line as modified. Main memory sees such data only when the line is later chosen for eviction.

On a miss the controller picks a victim way. A free (invalid) way is used first. Once the set is full, the choice follows a three-bit pseudo-LRU tree kept for each set. A modified victim is first copied out to memory in full. The missing line is then read in. A store miss merges its word into the newly loaded line, which leaves the line marked modified. Only one miss is handled at a time.

Both data interfaces use a handshake, with the following back-pressure rules:
- **Request port.** A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle. From the edge that takes a missing request until the edge that delivers its response, `req_ready` stays low.
- **Response port.** `rsp_valid` is a one-cycle pulse with no back-pressure, so the requester must always be ready to take it.
- **Memory port.** Once raised, `mem_req` holds its address, direction and write line steady until the edge on which `mem_ack` is sampled high. Read data is taken on that same edge.

Top module: `wb_cache_ctrl`

## Requirements
- R1: The request port carries a word address, which is the byte address with its two lowest bits dropped. Word-address bits [3:0] select the 32-bit word inside a line, bits [9:4] select one of 64 sets, and bits [29:10] form the 20-bit tag. Two addresses that differ only in the word field share a line.
- R2: After reset every line is invalid and every tree is zero. `req_ready` is 1, while `rsp_valid` and `mem_req` are both 0.
- R3: A hit needs a valid way in the indexed set whose tag matches. On a hit, `rsp_valid` pulses for one cycle on the edge after the request is taken, and no memory transaction takes place. For a read hit, `rsp_rdata` carries the stored word.
- R4: A store hit writes the word into the cached line and marks the line modified. It issues no memory write. A later read returns the stored word.
- R5: A read miss fetches the whole line with one memory read at line address {tag, set}. It installs the line as clean and returns the addressed word from it.
- R6: A store miss first reads the whole line, then merges the store word into it. The line is installed as modified, and its other words keep their memory contents.
- R7: The tree bits per set are ordered {right node, left node, root}. A root value of 0 means the older half is ways 0–1, and 1 means ways 2–3. In the left node, 0 names way 0 and 1 names way 1. In the right node, 0 names way 2 and 1 names way 3. Every hit and every fill points the nodes on the accessed way's path away from that way.
- R8: If a set has any invalid way, the lowest-numbered invalid way is filled and no valid line is displaced.
- R9: A modified victim is written to memory as its full line, at line address {victim tag, set}, before it is replaced. A clean victim is dropped without any memory write.
- R10: `req_ready` stays low from the edge that takes a miss until its response. `mem_req` keeps `mem_we` and `mem_laddr` stable until `mem_ack`.
- R11: A miss issues at most one write-back followed by exactly one refill read. The refill request follows the write-back acknowledge on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_waddr | input | 30 | Word address (tag, set, word) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data (meaningful for loads) |
| mem_req | output | 1 | Memory transaction pending |
| mem_ack | input | 1 | Memory completes the pending transaction this cycle |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_laddr | output | 26 | Line address {tag, set} |
| mem_wline | output | 512 | Line being written back |
| mem_rline | input | 512 | Refill line, sampled with `mem_ack` |

## Verification
Each response has a fixed arrival time, counted from the edge that takes the request:
- A hit answers exactly one cycle later.
- A clean miss answers after the memory latency plus two cycles.
- A miss with a modified victim needs two memory latencies plus three cycles.

The bench's memory model acknowledges a fixed number of cycles after it sees `mem_req`. The bench drives and samples on falling edges and counts cycles from the taking edge, so each latency check compares against that exact count. It also logs every memory transaction in order, which confirms that hits and stores to cached lines cause none and that a write-back always comes before its refill.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } wbc_state_e;

  // tree bits: [0] root, [1] left node (ways 0/1), [2] right node (ways 2/3)
  function automatic logic [WAY_W-1:0] tree_victim(input logic [2:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/wbc_tag_lookup.sv
module wbc_tag_lookup
  import wbc_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [IDX_W-1:0]                   lk_idx,
  input  logic [TAG_W-1:0]                   lk_tag,
  output logic                               hit,
  output logic [WAY_W-1:0]                   hit_way,
  output logic [NUM_WAYS-1:0]                valid_vec,
  output logic [NUM_WAYS-1:0]                dirty_vec,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]     set_tags,
  input  logic                               fill_en,
  input  logic [WAY_W-1:0]                   fill_way,
  input  logic [IDX_W-1:0]                   fill_idx,
  input  logic [TAG_W-1:0]                   fill_tag,
  input  logic                               fill_dirty,
  input  logic                               mark_en,
  input  logic [WAY_W-1:0]                   mark_way,
  input  logic [IDX_W-1:0]                   mark_idx
);
  localparam int SETS = 1 << IDX_W;

  logic [NUM_WAYS-1:0] hit_vec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (fill_en && fill_way == WAY_W'(w)) begin
        vld_q[fill_idx] <= 1'b1;
        drt_q[fill_idx] <= fill_dirty;
      end else if (mark_en && mark_way == WAY_W'(w)) begin
        drt_q[mark_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == WAY_W'(w)) tag_q[fill_idx] <= fill_tag;
    end

    assign set_tags[w]  = tag_q[lk_idx];
    assign valid_vec[w] = vld_q[lk_idx];
    assign dirty_vec[w] = drt_q[lk_idx];
    assign hit_vec[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !hit); // R5
endmodule

// File: rtl/wbc_plru.sv
module wbc_plru
  import wbc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     sel_idx,
  input  logic [NUM_WAYS-1:0]  valid_vec,
  output logic [WAY_W-1:0]     victim_way,
  input  logic                 touch_en,
  input  logic [IDX_W-1:0]     touch_idx,
  input  logic [WAY_W-1:0]     touch_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0][2:0] tree_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tree_q <= '0;
    else if (touch_en) tree_q[touch_idx] <= tree_touch(tree_q[touch_idx], touch_way);
  end

  // invalid ways first, lowest index wins; otherwise walk the tree
  always_comb begin
    victim_way = tree_victim(tree_q[sel_idx]);
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) victim_way = WAY_W'(w);
    end
  end

  AST_TOUCH_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (tree_victim(tree_q[$past(touch_idx)]) != $past(touch_way))); // R7
endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store
  import wbc_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int LINE_W = 512,
  parameter int WORD_W = 32
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [NUM_WAYS-1:0][LINE_W-1:0]   rd_lines,
  input  logic                              line_we,
  input  logic [WAY_W-1:0]                  line_way,
  input  logic [IDX_W-1:0]                  line_idx,
  input  logic [LINE_W-1:0]                 line_data,
  input  logic                              word_we,
  input  logic [WAY_W-1:0]                  word_way,
  input  logic [IDX_W-1:0]                  word_idx,
  input  logic [$clog2(LINE_W/WORD_W)-1:0]  word_sel,
  input  logic [WORD_W-1:0]                 word_data
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [LINE_W-1:0] arr_q [SETS];

    always_ff @(posedge clk) begin
      if (line_we && line_way == WAY_W'(w))
        arr_q[line_idx] <= line_data;
      else if (word_we && word_way == WAY_W'(w))
        arr_q[word_idx][word_sel*WORD_W +: WORD_W] <= word_data;
    end

    assign rd_lines[w] = arr_q[rd_idx];
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 6,
  parameter int WORD_W = 32,
  localparam int BSEL_W  = $clog2(WORD_W / 8),
  localparam int WADDR_W = ADDR_W - BSEL_W,
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W  = 8 << OFF_W,
  localparam int WSEL_W  = OFF_W - BSEL_W,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_we,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               mem_req,
  input  logic               mem_ack,
  output logic               mem_we,
  output logic [LADDR_W-1:0] mem_laddr,
  output logic [LINE_W-1:0]  mem_wline,
  input  logic [LINE_W-1:0]  mem_rline
);
  wbc_state_e               state_q;
  logic [WADDR_W-1:0]       pend_waddr;
  logic                     pend_we;
  logic [WORD_W-1:0]        pend_wdata;
  logic [WAY_W-1:0]         vict_q;

  logic [WADDR_W-1:0]       cur_waddr;
  logic [WSEL_W-1:0]        cur_wsel;
  logic [IDX_W-1:0]         cur_idx;
  logic [TAG_W-1:0]         cur_tag;

  logic                     hit;
  logic [WAY_W-1:0]         hit_way;
  logic [NUM_WAYS-1:0]      valid_vec;
  logic [NUM_WAYS-1:0]      dirty_vec;
  logic [NUM_WAYS-1:0][TAG_W-1:0]  set_tags;
  logic [NUM_WAYS-1:0][LINE_W-1:0] rd_lines;
  logic [WAY_W-1:0]         victim_way;

  logic                     accept, hit_acc, miss_acc, refill_done;
  logic                     store_hit;
  logic [WAY_W-1:0]         touch_way;
  logic [LINE_W-1:0]        merged_line;

  // the lookup follows the live request while idle, the held one during a miss
  assign cur_waddr = (state_q == ST_IDLE) ? req_waddr : pend_waddr;
  assign cur_wsel  = cur_waddr[WSEL_W-1:0];
  assign cur_idx   = cur_waddr[WSEL_W +: IDX_W];
  assign cur_tag   = cur_waddr[WADDR_W-1 -: TAG_W];

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign hit_acc     = accept && hit;
  assign miss_acc    = accept && !hit;
  assign refill_done = (state_q == ST_REFILL) && mem_ack;
  assign store_hit   = hit_acc && req_we;
  assign touch_way   = refill_done ? vict_q : hit_way;

  always_comb begin
    merged_line = mem_rline;
    if (pend_we) merged_line[cur_wsel*WORD_W +: WORD_W] = pend_wdata;
  end

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_EVICT);
  assign mem_laddr = (state_q == ST_EVICT) ? {set_tags[vict_q], cur_idx} : {cur_tag, cur_idx};
  assign mem_wline = rd_lines[vict_q];

  wbc_tag_lookup #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (cur_idx),
    .lk_tag     (cur_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .valid_vec  (valid_vec),
    .dirty_vec  (dirty_vec),
    .set_tags   (set_tags),
    .fill_en    (refill_done),
    .fill_way   (vict_q),
    .fill_idx   (cur_idx),
    .fill_tag   (cur_tag),
    .fill_dirty (pend_we),
    .mark_en    (store_hit),
    .mark_way   (hit_way),
    .mark_idx   (cur_idx)
  );

  wbc_plru #(.IDX_W(IDX_W)) u_plru (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_idx    (cur_idx),
    .valid_vec  (valid_vec),
    .victim_way (victim_way),
    .touch_en   (hit_acc || refill_done),
    .touch_idx  (cur_idx),
    .touch_way  (touch_way)
  );

  wbc_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
    .clk       (clk),
    .rd_idx    (cur_idx),
    .rd_lines  (rd_lines),
    .line_we   (refill_done),
    .line_way  (vict_q),
    .line_idx  (cur_idx),
    .line_data (merged_line),
    .word_we   (store_hit),
    .word_way  (hit_way),
    .word_idx  (cur_idx),
    .word_sel  (cur_wsel),
    .word_data (req_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_waddr <= '0;
      pend_we    <= 1'b0;
      pend_wdata <= '0;
      vict_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (hit_acc) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_lines[hit_way][cur_wsel*WORD_W +: WORD_W];
          end else if (miss_acc) begin
            pend_waddr <= req_waddr;
            pend_we    <= req_we;
            pend_wdata <= req_wdata;
            vict_q     <= victim_way;
            state_q    <= (valid_vec[victim_way] && dirty_vec[victim_way]) ? ST_EVICT : ST_REFILL;
          end
        end
        ST_EVICT: begin
          if (mem_ack) state_q <= ST_REFILL;
        end
        ST_REFILL: begin
          if (mem_ack) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= pend_we ? pend_wdata : mem_rline[cur_wsel*WORD_W +: WORD_W];
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && mem_we) |=> (mem_req && !mem_we)); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_laddr) && $stable(mem_we))); // R10
  AST_RSP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_ack && !mem_we))); // R3
endmodule

// File: tb/wb_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module wb_cache_ctrl_tb_top;
  localparam int CLK_NS  = 4;
  localparam int MEM_LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_we;
  logic         req_ready;
  logic [29:0]  req_waddr;
  logic [31:0]  req_wdata;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req, mem_we;
  logic         mem_ack;
  logic [25:0]  mem_laddr;
  logic [511:0] mem_wline;
  logic [511:0] mem_rline;

  wb_cache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_waddr(req_waddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_laddr(mem_laddr), .mem_wline(mem_wline), .mem_rline(mem_rline)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0]  ref_w [logic [29:0]];
  logic [511:0] mem_m [logic [25:0]];

  int           op_n;
  logic         op_we   [16];
  logic [25:0]  op_la   [16];
  logic [511:0] op_line [16];

  function automatic logic [31:0] seed_word(logic [25:0] la, logic [3:0] i);
    return {la[19:0], 8'hC0, i};
  endfunction

  function automatic logic [511:0] mem_line(logic [25:0] la);
    logic [511:0] l;
    if (mem_m.exists(la)) return mem_m[la];
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = seed_word(la, 4'(i));
    return l;
  endfunction

  function automatic logic [31:0] ref_read(logic [29:0] wa);
    if (ref_w.exists(wa)) return ref_w[wa];
    return seed_word(wa[29:4], wa[3:0]);
  endfunction

  function automatic logic [29:0] wa_of(logic [19:0] tag, logic [5:0] set, logic [3:0] w);
    return {tag, set, w};
  endfunction

  // memory model: acknowledges MEM_LAT cycles after it sees a request
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    mem_ack = 1'b0;
    mem_rline = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        if (wait_cnt == MEM_LAT) begin
          mem_ack = 1'b1;
          wait_cnt = 0;
          if (op_n < 16) begin
            op_we[op_n] = mem_we;
            op_la[op_n] = mem_laddr;
            op_line[op_n] = mem_wline;
          end
          op_n++;
          if (mem_we) mem_m[mem_laddr] = mem_wline;
          else mem_rline = mem_line(mem_laddr);
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [29:0] wa, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat, output bit rdy_low);
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_waddr = wa;
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    rdy_low = 1'b1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) rdy_low = 1'b0;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (we) ref_w[wa] = wd;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready after reset", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R2 rsp idle after reset", 32'(rsp_valid), 0);
    check(mem_req == 1'b0, "R2 no memory request after reset", 32'(mem_req), 0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int lat; bit rl;
    op_n = 0;
    access(1'b0, wa_of(20'h00011, 6'd1, 4'd3), '0, rd, lat, rl);
    check(rd == ref_read(wa_of(20'h00011, 6'd1, 4'd3)), "R5 read miss data", rd, ref_read(wa_of(20'h00011, 6'd1, 4'd3)));
    check(lat == MEM_LAT + 2, "R5 clean miss latency", 32'(lat), 32'(MEM_LAT + 2));
    check(op_n == 1 && op_we[0] == 1'b0 && op_la[0] == {20'h00011, 6'd1}, "R5 single refill read", 32'(op_n), 1);
    check(rl, "R10 ready low during miss", 32'(rl), 1);
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int lat; bit rl;
    op_n = 0;
    access(1'b0, wa_of(20'h00011, 6'd1, 4'd7), '0, rd, lat, rl);
    check(lat == 1, "R3 hit latency", 32'(lat), 1);
    check(rd == ref_read(wa_of(20'h00011, 6'd1, 4'd7)), "R1 R3 other word of same line hits", rd, ref_read(wa_of(20'h00011, 6'd1, 4'd7)));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R3 response is one pulse", 32'(rsp_valid), 0);
    check(op_n == 0, "R3 hit makes no memory access", 32'(op_n), 0);
    access(1'b0, wa_of(20'h00012, 6'd1, 4'd3), '0, rd, lat, rl);
    check(lat == MEM_LAT + 2, "R1 other tag same set misses", 32'(lat), 32'(MEM_LAT + 2));
    check(rd == ref_read(wa_of(20'h00012, 6'd1, 4'd3)), "R1 other tag data", rd, ref_read(wa_of(20'h00012, 6'd1, 4'd3)));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int lat; bit rl;
    op_n = 0;
    access(1'b1, wa_of(20'h00011, 6'd1, 4'd7), 32'hDEAD_0007, rd, lat, rl);
    check(lat == 1, "R4 store hit latency", 32'(lat), 1);
    access(1'b0, wa_of(20'h00011, 6'd1, 4'd7), '0, rd, lat, rl);
    check(rd == 32'hDEAD_0007, "R4 store hit read back", rd, 32'hDEAD_0007);
    check(op_n == 0, "R4 store hit writes no memory", 32'(op_n), 0);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int lat; bit rl;
    op_n = 0;
    access(1'b1, wa_of(20'h00022, 6'd2, 4'd5), 32'h5A5A_0005, rd, lat, rl);
    check(lat == MEM_LAT + 2, "R6 store miss latency", 32'(lat), 32'(MEM_LAT + 2));
    check(op_n == 1 && op_we[0] == 1'b0, "R6 store miss reads line first", 32'(op_n), 1);
    access(1'b0, wa_of(20'h00022, 6'd2, 4'd5), '0, rd, lat, rl);
    check(rd == 32'h5A5A_0005 && lat == 1, "R6 merged word read back", rd, 32'h5A5A_0005);
    access(1'b0, wa_of(20'h00022, 6'd2, 4'd6), '0, rd, lat, rl);
    check(rd == ref_read(wa_of(20'h00022, 6'd2, 4'd6)), "R6 untouched word from memory", rd, ref_read(wa_of(20'h00022, 6'd2, 4'd6)));
    check(op_n == 1, "R6 no write on store miss", 32'(op_n), 1);
  endtask

  task automatic t_replace();
    logic [31:0] rd; int lat; bit rl;
    op_n = 0;
    for (int k = 0; k < 4; k++) access(1'b0, wa_of(20'h00030 + 20'(k), 6'd3, 4'd0), '0, rd, lat, rl);
    check(op_n == 4, "R8 four fills into empty set", 32'(op_n), 4);
    for (int k = 0; k < 4; k++) begin
      access(1'b0, wa_of(20'h00030 + 20'(k), 6'd3, 4'd0), '0, rd, lat, rl);
      check(lat == 1, "R8 no resident displaced while ways free", 32'(lat), 1);
    end
    // touches w0,w1,w2,w3 then w0: tree points at way 2 (tag 32)
    access(1'b0, wa_of(20'h00030, 6'd3, 4'd0), '0, rd, lat, rl);
    op_n = 0;
    access(1'b0, wa_of(20'h00034, 6'd3, 4'd0), '0, rd, lat, rl);
    check(op_n == 1 && op_we[0] == 1'b0, "R9 clean victim not written back", 32'(op_n), 1);
    access(1'b0, wa_of(20'h00030, 6'd3, 4'd0), '0, rd, lat, rl);
    check(lat == 1, "R7 way 0 kept", 32'(lat), 1);
    access(1'b0, wa_of(20'h00031, 6'd3, 4'd0), '0, rd, lat, rl);
    check(lat == 1, "R7 way 1 kept", 32'(lat), 1);
    access(1'b0, wa_of(20'h00033, 6'd3, 4'd0), '0, rd, lat, rl);
    check(lat == 1, "R7 way 3 kept", 32'(lat), 1);
    access(1'b0, wa_of(20'h00032, 6'd3, 4'd0), '0, rd, lat, rl);
    check(lat == MEM_LAT + 2, "R7 tree victim way 2 was evicted", 32'(lat), 32'(MEM_LAT + 2));
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int lat; bit rl;
    logic [511:0] exp_l;
    for (int k = 0; k < 4; k++)
      access(1'b1, wa_of(20'h00050 + 20'(k), 6'd5, 4'd1), 32'hD000_0000 + 32'(k), rd, lat, rl);
    op_n = 0;
    access(1'b0, wa_of(20'h00054, 6'd5, 4'd0), '0, rd, lat, rl);
    check(lat == 2 * MEM_LAT + 3, "R9 dirty miss latency", 32'(lat), 32'(2 * MEM_LAT + 3));
    check(op_n == 2, "R11 write-back plus one refill", 32'(op_n), 2);
    check(op_we[0] == 1'b1 && op_la[0] == {20'h00050, 6'd5}, "R9 write-back address", 32'(op_la[0]), 32'({20'h00050, 6'd5}));
    exp_l = mem_line({20'h00050, 6'd5});
    check(op_line[0][63:32] == 32'hD000_0000, "R9 written-back store word", op_line[0][63:32], 32'hD000_0000);
    check(op_line[0][31:0] == seed_word({20'h00050, 6'd5}, 4'd0), "R9 written-back other word", op_line[0][31:0], exp_l[31:0]);
    check(op_we[1] == 1'b0 && op_la[1] == {20'h00054, 6'd5}, "R11 refill after write-back", 32'(op_la[1]), 32'({20'h00054, 6'd5}));
    check(rl, "R10 ready low through write-back", 32'(rl), 1);
    access(1'b0, wa_of(20'h00050, 6'd5, 4'd1), '0, rd, lat, rl);
    check(rd == 32'hD000_0000 && lat > 1, "R9 evicted data survives in memory", rd, 32'hD000_0000);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    op_n = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_we = 1'b0;
    req_waddr = '0;
    req_wdata = '0;
    repeat (3) @(posedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_replace();
    t_dirty_evict();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule